// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block sits beside the command bus of a single-data-rate SDRAM with four banks. It samples the bus on every rising clock edge and decodes one command per edge. It keeps a small state machine for each bank and counts the cycles of every timed state. Two device-wide operations, refresh and mode-register load, also keep the bus busy for a set time.

When a command does not fit the current state of the bank it addresses, or the state of the whole device, the block raises a violation flag for one cycle. The flag carries a code and a bank number. A rejected command changes no state. The block only observes: it does not drive the memory, model data or check electrical timing.

The timing limits are module parameters, counted in clock cycles: row-to-column delay, precharge time, refresh cycle time, mode-register delay and burst length.

Top module: `sdcmd_guard`

## Requirements
- R1: While reset is low, and on the first edge after it rises, the violation outputs are 0. Reset returns every bank to idle, so a READ sent straight after reset is reported as illegal for state.
- R2: Commands are decoded from the pins (sel_n, row_stb_n, col_stb_n, wr_en_n) as follows:

  | Pins | Command |
  |------|---------|
  | sel_n high | inhibit |
  | 0111 | NOP |
  | 0011 | ACTIVE |
  | 0101 | READ |
  | 0100 | WRITE |
  | 0110 | BURST STOP |
  | 0010 | PRECHARGE |
  | 0001 | REFRESH |
  | 0000 | MODE LOAD |

  Inhibit and NOP never raise a violation, whatever the clock-enable level.
- R3: ACTIVE is legal only on an idle bank. On a bank that is open or bursting it gives code 1 (illegal for state).
- R4: After an ACTIVE on edge k, any command other than NOP sent to that bank before edge k+T_RCD gives code 2 (busy). From edge k+T_RCD the bank is open.
- R5: READ and WRITE are legal on a bank that is open, reading or writing.
  - On an idle bank they give code 1.
  - BURST STOP is legal only during a burst that has no auto precharge, and it returns the bank to open. Anywhere else it gives code 1.
- R6: A burst started on edge k without auto precharge returns the bank to open on edge k+BURST_LEN.
- R7: With ap_all high, READ or WRITE selects auto precharge. The bank then answers with code 2 until edge k+BURST_LEN+T_RP, and it is idle from that edge on.
- R8: A PRECHARGE with ap_all low behaves as follows:
  - On an idle bank it is legal and changes nothing.
  - On an open or bursting bank it starts precharging, and the bank is idle from edge k+T_RP.
  - Any command to the bank before that edge gives code 2.
- R9: A PRECHARGE with ap_all high closes all banks. It gives code 2, reporting the lowest-numbered bank in a timed state, if any bank is activating, precharging or bursting with auto precharge.
- R10: REFRESH and MODE LOAD are legal only when all banks are idle. Otherwise they give code 3, reporting the lowest-numbered non-idle bank.
  - After an accepted REFRESH or MODE LOAD, every non-NOP command before edge k+T_RC or k+T_MRD respectively gives code 2, reporting the addressed bank.
- R11: With clk_en low:
  - The BURST STOP encoding means deep power-down. It is legal only with all banks idle, and otherwise gives code 3 with the lowest non-idle bank.
  - Any other selected non-NOP encoding gives code 4 (reserved), reporting the addressed bank.
- R12: A violation appears on viol_valid, viol_code and viol_bank in the cycle after the offending edge, and lasts one cycle. A rejected command does not change any bank state.
  - Codes: 0 = none, 1 = illegal for state, 2 = busy, 3 = not all idle, 4 = reserved.
  - Code and bank are 0 when there is no violation.
- R13: A command to one bank is checked only against that bank's own state, even while another bank is in a timed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; commands are sampled on rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock-enable level seen by the memory |
| sel_n | input | 1 | Chip select, active low |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bank_addr | input | 2 | Addressed bank |
| ap_all | input | 1 | Auto-precharge select on READ/WRITE; all-bank select on PRECHARGE |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Violation code |
| viol_bank | output | 2 | Bank named by the violation |

## Verification
The bench probes each timed state one cycle before it expires and again on the edge where it expires. A counter that is off by one therefore turns either an early busy into an accepted command or a legal command into a busy report.

It checks several interactions between states:
- A burst that has already finished is stopped, which must be reported as illegal rather than accepted.
- An auto-precharge write is followed by the full burst-plus-precharge wait.
- A precharge-all is sent while one bank is still activating.
- An illegal ACTIVE is sent in the middle of a read, which must not restart the activation count.

It also covers the clock-enable-low decode, including a deep power-down that is refused while a bank is open. It ends with a reset in the middle of activity, after which a READ must be refused because every bank is idle again.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST,
        CMD_PRE, CMD_REF, CMD_LMR, CMD_DPD, CMD_RSV
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE, BK_OPENING, BK_OPEN, BK_RD, BK_WR, BK_RDA, BK_WRA, BK_CLOSING
    } bank_st_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_ACT, OP_RD, OP_WR, OP_RDA, OP_WRA, OP_PRE, OP_BST
    } bank_op_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_STATE    = 3'd1,
        ERR_BUSY     = 3'd2,
        ERR_NOT_IDLE = 3'd3,
        ERR_RSV      = 3'd4
    } err_e;

    // States that accept nothing but NOP on their own bank
    function automatic logic is_timed(bank_st_e s);
        return (s == BK_OPENING) || (s == BK_CLOSING) || (s == BK_RDA) || (s == BK_WRA);
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic clk_en,
    input  logic sel_n,
    input  logic row_stb_n,
    input  logic col_stb_n,
    input  logic wr_en_n,
    output cmd_e cmd
);
    logic [2:0] pat;
    assign pat = {row_stb_n, col_stb_n, wr_en_n};

    always_comb begin
        cmd = CMD_NOP;
        if (!sel_n) begin
            if (clk_en) begin
                case (pat)
                    3'b111:  cmd = CMD_NOP;
                    3'b011:  cmd = CMD_ACT;
                    3'b101:  cmd = CMD_RD;
                    3'b100:  cmd = CMD_WR;
                    3'b110:  cmd = CMD_BST;
                    3'b010:  cmd = CMD_PRE;
                    3'b001:  cmd = CMD_REF;
                    default: cmd = CMD_LMR;
                endcase
            end else begin
                case (pat)
                    3'b111:  cmd = CMD_NOP;
                    3'b110:  cmd = CMD_DPD;
                    default: cmd = CMD_RSV;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bank_op_e op,
    output bank_st_e eff_st
);
    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_BL  = CNT_W'(BURST_LEN - 1);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } bank_t;

    bank_t q, d, base_d;
    logic  expired;

    // Effective state and the step taken when no command arrives
    always_comb begin
        expired = (q.cnt == '0);
        eff_st  = q.st;
        base_d  = q;
        case (q.st)
            BK_OPENING, BK_RD, BK_WR: begin
                if (expired) begin
                    eff_st = BK_OPEN;
                    base_d = '{st: BK_OPEN, cnt: '0};
                end else begin
                    base_d.cnt = q.cnt - CNT_W'(1);
                end
            end
            BK_RDA, BK_WRA: begin
                if (expired) begin
                    eff_st = BK_CLOSING;
                    base_d = '{st: BK_CLOSING, cnt: LD_RP};
                end else begin
                    base_d.cnt = q.cnt - CNT_W'(1);
                end
            end
            BK_CLOSING: begin
                if (expired) begin
                    eff_st = BK_IDLE;
                    base_d = '{st: BK_IDLE, cnt: '0};
                end else begin
                    base_d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase
    end

    // Accepted command overrides the free-running step
    always_comb begin
        d = base_d;
        case (op)
            OP_ACT: d = '{st: BK_OPENING, cnt: LD_RCD};
            OP_RD:  d = '{st: BK_RD,      cnt: LD_BL};
            OP_WR:  d = '{st: BK_WR,      cnt: LD_BL};
            OP_RDA: d = '{st: BK_RDA,     cnt: LD_BL};
            OP_WRA: d = '{st: BK_WRA,     cnt: LD_BL};
            OP_BST: d = '{st: BK_OPEN,    cnt: '0};
            OP_PRE: d = (eff_st == BK_IDLE) ? '{st: BK_IDLE, cnt: '0}
                                            : '{st: BK_CLOSING, cnt: LD_RP};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3
    act_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACT) |-> (eff_st == BK_IDLE));
    // R4
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACT) |=> (q.st == BK_OPENING));
    // R5
    col_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD || op == OP_WR || op == OP_RDA || op == OP_WRA)
        |-> (eff_st == BK_OPEN || eff_st == BK_RD || eff_st == BK_WR));
    // R5
    stop_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BST) |-> (eff_st == BK_RD || eff_st == BK_WR));
    // R8
    pre_not_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PRE) |-> !is_timed(eff_st));
endmodule

// File: rtl/sdcmd_guard.sv
module sdcmd_guard
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 6,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clk_en,
    input  logic                         sel_n,
    input  logic                         row_stb_n,
    input  logic                         col_stb_n,
    input  logic                         wr_en_n,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_addr,
    input  logic                         ap_all,
    output logic                         viol_valid,
    output logic [2:0]                   viol_code,
    output logic [$clog2(NUM_BANKS)-1:0] viol_bank
);
    localparam int BA_W   = $clog2(NUM_BANKS);
    localparam int BK_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int BK_MAX = (BK_A > BURST_LEN) ? BK_A : BURST_LEN;
    localparam int CNT_W  = $clog2(BK_MAX + 1);
    localparam int G_MAX  = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int GC_W   = $clog2(G_MAX + 1);
    localparam logic [GC_W-1:0] LD_RC  = GC_W'(T_RC - 1);
    localparam logic [GC_W-1:0] LD_MRD = GC_W'(T_MRD - 1);

    cmd_e     cmd;
    bank_op_e op_vec  [NUM_BANKS];
    bank_st_e eff_vec [NUM_BANKS];

    sdcmd_decode u_dec (
        .clk_en    (clk_en),
        .sel_n     (sel_n),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .wr_en_n   (wr_en_n),
        .cmd       (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdcmd_bank #(
            .T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op_vec[b]),
            .eff_st (eff_vec[b])
        );
    end

    typedef struct packed {
        logic            vld;
        err_e            code;
        logic [BA_W-1:0] bank;
        logic [GC_W-1:0] gcnt;
    } guard_t;

    guard_t q, d;
    logic all_idle, any_timed, g_busy;
    logic [BA_W-1:0] first_timed, first_open;
    bank_st_e sel_st;

    // Device-wide summary of the bank states
    always_comb begin
        all_idle    = 1'b1;
        any_timed   = 1'b0;
        first_timed = '0;
        first_open  = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (eff_vec[b] != BK_IDLE) begin
                all_idle   = 1'b0;
                first_open = BA_W'(b);
            end
            if (is_timed(eff_vec[b])) begin
                any_timed   = 1'b1;
                first_timed = BA_W'(b);
            end
        end
        sel_st = eff_vec[bank_addr];
        g_busy = (q.gcnt != '0);
    end

    always_comb begin
        err_e            err;
        logic [BA_W-1:0] eb;
        err = ERR_NONE;
        eb  = bank_addr;
        for (int b = 0; b < NUM_BANKS; b++) op_vec[b] = OP_NONE;
        d.gcnt = g_busy ? (q.gcnt - GC_W'(1)) : '0;

        if (cmd == CMD_NOP) begin
            err = ERR_NONE;
        end else if (cmd == CMD_RSV) begin
            err = ERR_RSV;
        end else if (g_busy) begin
            err = ERR_BUSY;
        end else begin
            case (cmd)
                CMD_ACT: begin
                    if (sel_st == BK_IDLE)  op_vec[bank_addr] = OP_ACT;
                    else if (is_timed(sel_st)) err = ERR_BUSY;
                    else                    err = ERR_STATE;
                end
                CMD_RD, CMD_WR: begin
                    if (sel_st == BK_OPEN || sel_st == BK_RD || sel_st == BK_WR)
                        op_vec[bank_addr] = (cmd == CMD_RD) ? (ap_all ? OP_RDA : OP_RD)
                                                            : (ap_all ? OP_WRA : OP_WR);
                    else if (is_timed(sel_st)) err = ERR_BUSY;
                    else                       err = ERR_STATE;
                end
                CMD_BST: begin
                    if (sel_st == BK_RD || sel_st == BK_WR) op_vec[bank_addr] = OP_BST;
                    else if (is_timed(sel_st))              err = ERR_BUSY;
                    else                                    err = ERR_STATE;
                end
                CMD_PRE: begin
                    if (ap_all) begin
                        if (any_timed) begin
                            err = ERR_BUSY;
                            eb  = first_timed;
                        end else begin
                            for (int b = 0; b < NUM_BANKS; b++) op_vec[b] = OP_PRE;
                        end
                    end else if (is_timed(sel_st)) begin
                        err = ERR_BUSY;
                    end else begin
                        op_vec[bank_addr] = OP_PRE;
                    end
                end
                CMD_REF, CMD_LMR: begin
                    if (!all_idle) begin
                        err = ERR_NOT_IDLE;
                        eb  = first_open;
                    end else begin
                        d.gcnt = (cmd == CMD_REF) ? LD_RC : LD_MRD;
                    end
                end
                CMD_DPD: begin
                    if (!all_idle) begin
                        err = ERR_NOT_IDLE;
                        eb  = first_open;
                    end
                end
                default: ;
            endcase
        end

        d.vld  = (err != ERR_NONE);
        d.code = err;
        d.bank = (err != ERR_NONE) ? eb : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign viol_valid = q.vld;
    assign viol_code  = q.code;
    assign viol_bank  = q.bank;

    // R10
    quiet_during_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_busy |-> all_idle);
    // R10
    ref_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF && !all_idle) |=> viol_valid);
    // R11
    cke_low_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !sel_n && !(row_stb_n && col_stb_n)) |=> (viol_valid && viol_code == 3'd4));
    // R12
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_code >= 3'd1 && viol_code <= 3'd4));
endmodule

// File: tb/test_sdcmd_guard.sv
module test_sdcmd_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       clk_en, sel_n, row_stb_n, col_stb_n, wr_en_n, ap_all;
    logic [1:0] bank_addr;
    logic       viol_valid;
    logic [2:0] viol_code;
    logic [1:0] viol_bank;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sdcmd_guard i_sdcmd_guard (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n), .wr_en_n(wr_en_n),
        .bank_addr(bank_addr), .ap_all(ap_all),
        .viol_valid(viol_valid), .viol_code(viol_code), .viol_bank(viol_bank)
    );

    // Pin patterns {sel_n, row, col, we}
    localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD  = 4'b0101,
                           P_WR  = 4'b0100, P_BST = 4'b0110, P_PRE = 4'b0010,
                           P_REF = 4'b0001, P_LMR = 4'b0000, P_INH = 4'b1000;

    // Vector: {clk_en, pins[4], bank[2], ap, exp_code[3], exp_bank[2], req[4]}
    localparam int NV = 46;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, P_ACT, 2'd0, 1'b0, 3'd0, 2'd0, 4'd3 },  //  0 R3 open bank0
        {1'b1, P_RD,  2'd0, 1'b0, 3'd2, 2'd0, 4'd4 },  //  1 R4 too early
        {1'b1, P_ACT, 2'd1, 1'b0, 3'd0, 2'd0, 4'd13},  //  2 R13 other bank free
        {1'b1, P_RD,  2'd0, 1'b0, 3'd0, 2'd0, 4'd4 },  //  3 R4 exactly at tRCD
        {1'b1, P_ACT, 2'd0, 1'b0, 3'd1, 2'd0, 4'd3 },  //  4 R3 active on reading bank
        {1'b1, P_BST, 2'd1, 1'b0, 3'd1, 2'd1, 4'd5 },  //  5 R5 stop on open bank
        {1'b1, P_WR,  2'd1, 1'b1, 3'd0, 2'd0, 4'd7 },  //  6 R7 write with auto precharge
        {1'b1, P_BST, 2'd0, 1'b0, 3'd1, 2'd0, 4'd6 },  //  7 R6 burst done; R12 edge 4 left no trace
        {1'b1, P_WR,  2'd0, 1'b0, 3'd0, 2'd0, 4'd5 },  //  8 R5
        {1'b1, P_BST, 2'd0, 1'b0, 3'd0, 2'd0, 4'd5 },  //  9 R5 stop write
        {1'b1, P_BST, 2'd0, 1'b0, 3'd1, 2'd0, 4'd5 },  // 10 R5 back to open
        {1'b1, P_REF, 2'd2, 1'b0, 3'd3, 2'd0, 4'd10},  // 11 R10 not idle
        {1'b1, P_ACT, 2'd1, 1'b0, 3'd2, 2'd1, 4'd7 },  // 12 R7 one edge early
        {1'b1, P_ACT, 2'd1, 1'b0, 3'd0, 2'd0, 4'd7 },  // 13 R7 idle on time
        {1'b1, P_PRE, 2'd3, 1'b1, 3'd2, 2'd1, 4'd9 },  // 14 R9 bank1 activating
        {1'b1, P_RD,  2'd2, 1'b0, 3'd1, 2'd2, 4'd5 },  // 15 R5 read on idle
        {1'b1, P_PRE, 2'd0, 1'b1, 3'd0, 2'd0, 4'd9 },  // 16 R9 close all
        {1'b1, P_PRE, 2'd2, 1'b0, 3'd0, 2'd0, 4'd8 },  // 17 R8 idle bank
        {1'b1, P_LMR, 2'd0, 1'b0, 3'd3, 2'd0, 4'd10},  // 18 R10 still closing
        {1'b1, P_LMR, 2'd0, 1'b0, 3'd0, 2'd0, 4'd10},  // 19 R9 all idle after tRP
        {1'b1, P_ACT, 2'd3, 1'b0, 3'd2, 2'd3, 4'd10},  // 20 R10 inside tMRD
        {1'b1, P_ACT, 2'd3, 1'b0, 3'd0, 2'd0, 4'd10},  // 21 R10 tMRD over
        {1'b1, P_INH, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 22 R2 inhibit
        {1'b0, P_ACT, 2'd2, 1'b0, 3'd4, 2'd2, 4'd11},  // 23 R11 reserved
        {1'b0, P_BST, 2'd0, 1'b0, 3'd3, 2'd3, 4'd11},  // 24 R11 power-down refused
        {1'b1, P_PRE, 2'd3, 1'b0, 3'd0, 2'd0, 4'd8 },  // 25 R8
        {1'b1, P_PRE, 2'd3, 1'b0, 3'd2, 2'd3, 4'd8 },  // 26 R8 busy precharging
        {1'b0, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 27 R2 nop, clk_en low
        {1'b0, P_BST, 2'd0, 1'b0, 3'd0, 2'd0, 4'd11},  // 28 R11 power-down accepted
        {1'b1, P_REF, 2'd0, 1'b0, 3'd0, 2'd0, 4'd10},  // 29 R10 refresh
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 30
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 31
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 32
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 33
        {1'b1, P_ACT, 2'd0, 1'b0, 3'd2, 2'd0, 4'd10},  // 34 R10 last tRC edge
        {1'b1, P_ACT, 2'd0, 1'b0, 3'd0, 2'd0, 4'd10},  // 35 R10 tRC over
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 36
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 37
        {1'b1, P_RD,  2'd0, 1'b1, 3'd0, 2'd0, 4'd7 },  // 38 R7 read with auto precharge
        {1'b1, P_RD,  2'd0, 1'b0, 3'd2, 2'd0, 4'd7 },  // 39 R7 busy
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd12},  // 40 R12 pulse ended
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 41
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 42
        {1'b1, P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, 4'd2 },  // 43
        {1'b1, P_ACT, 2'd0, 1'b0, 3'd2, 2'd0, 4'd7 },  // 44 R7 one edge early
        {1'b1, P_ACT, 2'd0, 1'b0, 3'd0, 2'd0, 4'd7 }   // 45 R7 idle on time
    };

    task automatic drive(input logic ce, input logic [3:0] p, input logic [1:0] b, input logic ap);
        clk_en = ce;
        {sel_n, row_stb_n, col_stb_n, wr_en_n} = p;
        bank_addr = b;
        ap_all = ap;
    endtask

    task automatic check(input int req, input logic [2:0] ecode, input logic [1:0] ebank);
        logic evld;
        evld = (ecode != 3'd0);
        total++;
        if (viol_valid !== evld || viol_code !== ecode || viol_bank !== ebank) begin
            fails++;
            $display("FAIL R%0d: got valid=%0b code=%0d bank=%0d, expected valid=%0b code=%0d bank=%0d",
                     req, viol_valid, viol_code, viol_bank, evld, ecode, ebank);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b1, P_NOP, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        check(1, 3'd0, 2'd0);                     // R1 outputs quiet in reset
        rst_n = 1'b1;
        drive(VEC[0][16], VEC[0][15:12], VEC[0][11:10], VEC[0][9]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(int'(VEC[i][3:0]), VEC[i][8:6], VEC[i][5:4]);
            if (i + 1 < NV)
                drive(VEC[i+1][16], VEC[i+1][15:12], VEC[i+1][11:10], VEC[i+1][9]);
            else
                drive(1'b1, P_NOP, 2'd0, 1'b0);
        end

        // R1: reset in the middle of activity returns banks to idle
        @(negedge clk);
        drive(1'b1, P_ACT, 2'd2, 1'b0);
        @(negedge clk);
        check(1, 3'd0, 2'd0);
        drive(1'b1, P_RD, 2'd2, 1'b0);
        @(negedge clk);
        check(4, 3'd2, 2'd2);                     // R4 bank2 still opening
        rst_n = 1'b0;
        drive(1'b1, P_RD, 2'd2, 1'b0);
        @(negedge clk);
        check(1, 3'd0, 2'd0);                     // R1 no report while in reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 3'd1, 2'd2);                     // R1 bank2 idle after reset
        drive(1'b1, P_ACT, 2'd2, 1'b0);
        @(negedge clk);
        check(3, 3'd0, 2'd0);                     // R3 ACTIVE legal after reset
        drive(1'b1, P_NOP, 2'd0, 1'b0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule